// File: doc/BRIEF.md
# Addressed SPI Register Port for a 16-Pin I/O Expander

This block is the serial front end of a two-bank, 16-pin I/O expander. A host talks to it over a mode-0 SPI link. Several copies of the expander can sit on one chip select, and each copy is told apart by a 3-bit address strapped on its pins. Every frame opens with a control byte that holds a fixed device prefix, the target's address and a read/write flag. The register address comes next, followed by one or more data bytes. In a write frame the host sends the data bytes. In a read frame the target shifts the data bytes out on MISO.

The register file holds, for each bank, a pin direction, an input inversion mask, a pull-up enable and an output latch. It also holds one configuration byte that is visible at the addresses of both banks. The configuration byte controls two things: whether the address field of the control byte is compared at all, and whether the register address advances after each data byte. The pin-facing outputs come straight from the registers. Reading the port returns the sampled pins after polarity inversion.

Top module: `gpx_spi_regport`

## Requirements
- R1: After reset the direction register is all ones, so `pin_oe` is 16'h0000. The output latch, pull-up, polarity and configuration registers are all zero.
- R2: A frame is ignored if bits 7:4 of its control byte are not 4'b0100. It then writes nothing and drives nothing on MISO.
- R3: When configuration bit 3 (address compare) is 1, a frame whose control bits 3:1 differ from `hw_addr` is ignored. A frame whose bits match is served.
- R4: When configuration bit 3 is 0, control bits 3:1 are ignored and every target serves the frame. Control bit 0 selects the access: 1 is a read and 0 is a write.
- R5: A register address is 2*index + bank, with bank A at the even address. The map is: direction 0x00/0x01, polarity 0x02/0x03, configuration 0x0A/0x0B, pull-up 0x0C/0x0D, port 0x12/0x13, latch 0x14/0x15. Every other address reads as 0x00, and writes to it change nothing.
- R6: When configuration bit 5 is 0, the register address advances by one after each data byte. After 0x15 it wraps to 0x00.
- R7: When configuration bit 5 is 1, every data byte of a frame goes to the same register address.
- R8: The configuration register is a single byte. A write at 0x0A or at 0x0B updates it, and both addresses read back the same value.
- R9: A write to a port address changes the output latch of that bank, and `pin_out` follows the latch. A read of a latch address returns the latch, not the pin levels.
- R10: A read of a port address returns `pin_in` XOR the polarity mask for that bank.
- R11: `pin_oe` is the inverse of the direction register (a 0 bit drives the pin), and `pull_en` equals the pull-up register.
- R12: Raising `spi_cs_n` ends a frame at any bit. A partly received byte is thrown away, and the next frame starts again at the control byte.
- R13: Read data is shifted MSB first in mode 0. It changes after SCLK falls and is valid at the rising edge. `spi_miso_oe` is high only during the data phase of a read frame that is being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; SPI lines are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Shared chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read data to the host |
| spi_miso_oe | output | 1 | High while this target owns the MISO line |
| hw_addr | input | 3 | Strapped target address |
| pin_in | input | 16 | Sampled pin levels, bank A in bits 7:0 |
| pin_out | output | 16 | Output latch value driven toward the pins |
| pin_oe | output | 16 | Per-pin drive enable (1 = output) |
| pull_en | output | 16 | Per-pin pull-up enable |

## Verification
On every cycle the assertions check these rules: an ignored frame never writes or drives MISO, a raised chip select returns the decoder to the control-byte phase, the address advances or holds according to configuration bit 5, a write to an unmapped address leaves every register untouched, and direction comes out of reset as all ones. The bench scenarios are the only way to show behaviour that needs whole frames. These include matching the address against the strap with compare on and off, the exact register map with bank ordering, the mirrored configuration byte, the latch-versus-pin readback, polarity inversion, wrap-around at the top of the map, and recovery after frames cut off mid-byte.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    // frame decoder phases
    typedef enum logic [1:0] {
        PH_CTRL = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_SKIP = 2'd3
    } phase_e;

    localparam int BANK_W   = 8;
    localparam int N_BANKS  = 2;
    localparam int PINS     = BANK_W * N_BANKS;

    // register indices; address = 2*index + bank
    localparam logic [6:0] IDX_DIR  = 7'd0;
    localparam logic [6:0] IDX_POL  = 7'd1;
    localparam logic [6:0] IDX_CFG  = 7'd5;
    localparam logic [6:0] IDX_PULL = 7'd6;
    localparam logic [6:0] IDX_PORT = 7'd9;
    localparam logic [6:0] IDX_LAT  = 7'd10;

    localparam logic [7:0] LAST_ADDR = 8'h15;

    localparam int CFG_ADDR_EN_BIT = 3;
    localparam int CFG_FIXED_BIT   = 5;

    localparam logic [3:0] CTRL_PREFIX = 4'b0100;

    function automatic logic [7:0] next_addr(input logic [7:0] a, input logic fixed);
        if (fixed)
            return a;
        else if (a >= LAST_ADDR)
            return 8'h00;
        else
            return a + 8'h01;
    endfunction

endpackage

// File: rtl/gpx_spi_sync.sv
module gpx_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_idle,
    output logic mosi_s
);

    typedef struct packed {
        logic [STAGES-1:0] sclk_sh;
        logic [STAGES-1:0] cs_sh;
        logic [STAGES-1:0] mosi_sh;
        logic              sclk_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d           = sync_q;
        sync_d.sclk_sh   = {sync_q.sclk_sh[STAGES-2:0], sclk};
        sync_d.cs_sh     = {sync_q.cs_sh[STAGES-2:0], cs_n};
        sync_d.mosi_sh   = {sync_q.mosi_sh[STAGES-2:0], mosi};
        sync_d.sclk_prev = sync_q.sclk_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.sclk_sh   <= '0;
            sync_q.cs_sh     <= '1;
            sync_q.mosi_sh   <= '0;
            sync_q.sclk_prev <= 1'b0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sclk_rise = sync_q.sclk_sh[STAGES-1] & ~sync_q.sclk_prev;
    assign sclk_fall = ~sync_q.sclk_sh[STAGES-1] & sync_q.sclk_prev;
    assign cs_idle   = sync_q.cs_sh[STAGES-1];
    assign mosi_s    = sync_q.mosi_sh[STAGES-1];

endmodule

// File: rtl/gpx_frame.sv
module gpx_frame
    import gpx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_rise,
    input  logic       sclk_fall,
    input  logic       cs_idle,
    input  logic       mosi_s,
    input  logic [2:0] strap,
    input  logic       cfg_addr_en,
    input  logic       cfg_fixed,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_addr,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       miso,
    output logic       miso_oe
);

    typedef struct packed {
        phase_e     phase;
        logic [2:0] bit_cnt;
        logic [7:0] rx;
        logic [7:0] tx;
        logic [7:0] ptr;
        logic       is_rd;
    } frame_t;

    frame_t fr_d, fr_q;

    logic [7:0] byte_v;
    logic       byte_done;
    logic       data_done;
    logic [7:0] ptr_next;
    logic       ctrl_hit;

    assign byte_v    = {fr_q.rx[6:0], mosi_s};
    assign byte_done = !cs_idle && sclk_rise && (fr_q.bit_cnt == 3'd7);
    assign data_done = byte_done && (fr_q.phase == PH_DATA);
    assign ptr_next  = next_addr(fr_q.ptr, cfg_fixed);
    assign ctrl_hit  = (byte_v[7:4] == CTRL_PREFIX) &&
                       (!cfg_addr_en || (byte_v[3:1] == strap));

    always_comb begin
        fr_d    = fr_q;
        wr_en   = 1'b0;
        wr_addr = fr_q.ptr;
        wr_data = byte_v;
        rd_addr = fr_q.ptr;
        if (cs_idle) begin
            fr_d.phase   = PH_CTRL;
            fr_d.bit_cnt = 3'd0;
            fr_d.tx      = 8'h00;
            fr_d.is_rd   = 1'b0;
        end else begin
            if (sclk_fall && (fr_q.bit_cnt != 3'd0))
                fr_d.tx = {fr_q.tx[6:0], 1'b0};
            if (sclk_rise) begin
                fr_d.rx      = byte_v;
                fr_d.bit_cnt = fr_q.bit_cnt + 3'd1;
                if (fr_q.bit_cnt == 3'd7) begin
                    unique case (fr_q.phase)
                        PH_CTRL: begin
                            fr_d.is_rd = byte_v[0];
                            fr_d.phase = ctrl_hit ? PH_ADDR : PH_SKIP;
                        end
                        PH_ADDR: begin
                            fr_d.ptr   = byte_v;
                            fr_d.phase = PH_DATA;
                            rd_addr    = byte_v;
                            if (fr_q.is_rd)
                                fr_d.tx = rd_data;
                        end
                        PH_DATA: begin
                            fr_d.ptr = ptr_next;
                            if (fr_q.is_rd) begin
                                rd_addr = ptr_next;
                                fr_d.tx = rd_data;
                            end else begin
                                wr_en = 1'b1;
                            end
                        end
                        PH_SKIP: begin
                            fr_d.phase = PH_SKIP;
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q.phase   <= PH_CTRL;
            fr_q.bit_cnt <= 3'd0;
            fr_q.rx      <= 8'h00;
            fr_q.tx      <= 8'h00;
            fr_q.ptr     <= 8'h00;
            fr_q.is_rd   <= 1'b0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign miso    = fr_q.tx[7];
    assign miso_oe = (fr_q.phase == PH_DATA) && fr_q.is_rd;

    // an ignored frame never reaches the register file
    assert_skip_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.phase == PH_SKIP) |-> !wr_en);

    // chip select high returns the decoder to the control byte
    assert_abort_to_ctrl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> (fr_q.phase == PH_CTRL) && (fr_q.bit_cnt == 3'd0));

    // MISO is released once chip select goes high
    assert_release_miso_R13: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> !miso_oe);

    // sequential mode advances the pointer by one below the top of the map
    assert_ptr_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_done && !cfg_fixed && (fr_q.ptr < LAST_ADDR)) |=>
            (fr_q.ptr == $past(fr_q.ptr) + 8'h01));

    // fixed mode keeps the pointer in place
    assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_done && cfg_fixed) |=> $stable(fr_q.ptr));

endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
    import gpx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      wr_addr,
    input  logic [7:0]      wr_data,
    input  logic [7:0]      rd_addr,
    input  logic [PINS-1:0] pin_in,
    output logic [7:0]      rd_data,
    output logic [PINS-1:0] dir,
    output logic [PINS-1:0] lat,
    output logic [PINS-1:0] pull,
    output logic [7:0]      cfg
);

    typedef struct packed {
        logic [PINS-1:0] dir;
        logic [PINS-1:0] pol;
        logic [PINS-1:0] pull;
        logic [PINS-1:0] lat;
        logic [7:0]      cfg;
    } regs_t;

    regs_t rg_d, rg_q;

    logic [6:0] wr_idx, rd_idx;
    logic       wr_bank, rd_bank;
    logic       wr_hit;
    logic [PINS-1:0] port_view;

    assign wr_idx    = wr_addr[7:1];
    assign wr_bank   = wr_addr[0];
    assign rd_idx    = rd_addr[7:1];
    assign rd_bank   = rd_addr[0];
    assign port_view = pin_in ^ rg_q.pol;

    always_comb begin
        rg_d   = rg_q;
        wr_hit = 1'b0;
        if (wr_en) begin
            wr_hit = 1'b1;
            case (wr_idx)
                IDX_DIR:  rg_d.dir[wr_bank*BANK_W +: BANK_W]  = wr_data;
                IDX_POL:  rg_d.pol[wr_bank*BANK_W +: BANK_W]  = wr_data;
                IDX_CFG:  rg_d.cfg                            = wr_data;
                IDX_PULL: rg_d.pull[wr_bank*BANK_W +: BANK_W] = wr_data;
                IDX_PORT,
                IDX_LAT:  rg_d.lat[wr_bank*BANK_W +: BANK_W]  = wr_data;
                default:  wr_hit = 1'b0;
            endcase
        end
    end

    always_comb begin
        case (rd_idx)
            IDX_DIR:  rd_data = rg_q.dir[rd_bank*BANK_W +: BANK_W];
            IDX_POL:  rd_data = rg_q.pol[rd_bank*BANK_W +: BANK_W];
            IDX_CFG:  rd_data = rg_q.cfg;
            IDX_PULL: rd_data = rg_q.pull[rd_bank*BANK_W +: BANK_W];
            IDX_PORT: rd_data = port_view[rd_bank*BANK_W +: BANK_W];
            IDX_LAT:  rd_data = rg_q.lat[rd_bank*BANK_W +: BANK_W];
            default:  rd_data = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q.dir  <= '1;
            rg_q.pol  <= '0;
            rg_q.pull <= '0;
            rg_q.lat  <= '0;
            rg_q.cfg  <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign dir  = rg_q.dir;
    assign lat  = rg_q.lat;
    assign pull = rg_q.pull;
    assign cfg  = rg_q.cfg;

    // direction leaves reset as all inputs
    assert_dir_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rg_q.dir == '1) && (rg_q.lat == '0));

    // a write outside the map leaves every register untouched
    assert_unmapped_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hit) |=> $stable(rg_q));

endmodule

// File: rtl/gpx_spi_regport.sv
module gpx_spi_regport
    import gpx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            spi_sclk,
    input  logic            spi_cs_n,
    input  logic            spi_mosi,
    output logic            spi_miso,
    output logic            spi_miso_oe,
    input  logic [2:0]      hw_addr,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_oe,
    output logic [PINS-1:0] pull_en
);

    logic       sclk_rise, sclk_fall, cs_idle, mosi_s;
    logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
    logic       wr_en;
    logic [7:0] cfg;
    logic [PINS-1:0] dir;

    gpx_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_idle   (cs_idle),
        .mosi_s    (mosi_s)
    );

    gpx_frame u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_rise   (sclk_rise),
        .sclk_fall   (sclk_fall),
        .cs_idle     (cs_idle),
        .mosi_s      (mosi_s),
        .strap       (hw_addr),
        .cfg_addr_en (cfg[CFG_ADDR_EN_BIT]),
        .cfg_fixed   (cfg[CFG_FIXED_BIT]),
        .rd_data     (rd_data),
        .rd_addr     (rd_addr),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .miso        (spi_miso),
        .miso_oe     (spi_miso_oe)
    );

    gpx_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .pin_in  (pin_in),
        .rd_data (rd_data),
        .dir     (dir),
        .lat     (pin_out),
        .pull    (pull_en),
        .cfg     (cfg)
    );

    assign pin_oe = ~dir;

endmodule

// File: tb/gpx_spi_regport_bench.sv
module gpx_spi_regport_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCLK  = 8;
    localparam logic [2:0] STRAP = 3'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso, miso_oe;
    logic [15:0] pin_in = 16'h0000;
    logic [15:0] pin_out, pin_oe, pull_en;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpx_spi_regport u_gpx_spi_regport (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sclk    (sclk),
        .spi_cs_n    (cs_n),
        .spi_mosi    (mosi),
        .spi_miso    (miso),
        .spi_miso_oe (miso_oe),
        .hw_addr     (STRAP),
        .pin_in      (pin_in),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .pull_en     (pull_en)
    );

    task automatic check16(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // shift nbits of tx (MSB first); returns the bits seen on MISO
    task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = tx[i];
            wait_clks(HALF_SCLK);
            rx[i] = miso;
            sclk = 1'b1;
            wait_clks(HALF_SCLK);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_begin();
        @(negedge clk);
        cs_n = 1'b0;
        wait_clks(HALF_SCLK);
    endtask

    task automatic cs_end();
        wait_clks(HALF_SCLK);
        cs_n = 1'b1;
        wait_clks(2 * HALF_SCLK);
    endtask

    task automatic wr_frame(input logic [7:0] ctrl, input logic [7:0] addr,
                            input logic [7:0] d0, input logic [7:0] d1, input int n);
        logic [7:0] rx;
        cs_begin();
        spi_bits(ctrl, 8, rx);
        spi_bits(addr, 8, rx);
        spi_bits(d0, 8, rx);
        if (n > 1) spi_bits(d1, 8, rx);
        if (n > 2) spi_bits(d0, 8, rx);
        cs_end();
    endtask

    // expected bytes are pushed by the caller beforehand
    task automatic rd_frame(input logic [7:0] ctrl, input logic [7:0] addr, input int n);
        logic [7:0] rx;
        cs_begin();
        spi_bits(ctrl, 8, rx);
        spi_bits(addr, 8, rx);
        wait_clks(4);
        checks++;
        if (miso_oe !== 1'b1) begin
            errors++;
            $display("FAIL R13 miso_oe in read data phase: got %b expected 1", miso_oe);
        end
        for (int k = 0; k < n; k++) begin
            spi_bits(8'h00, 8, rx);
            got_q.push_back(rx);
        end
        cs_end();
        checks++;
        if (miso_oe !== 1'b0) begin
            errors++;
            $display("FAIL R13 miso_oe after frame: got %b expected 0", miso_oe);
        end
    endtask

    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (got_q.size() > 0) begin
                logic [7:0] g, e;
                string t;
                g = got_q.pop_front();
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected read byte: got %h expected none", g);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (g !== e) begin
                        errors++;
                        $display("FAIL %s: got %h expected %h", t, g, e);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rx;
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(5);

        // R1 reset state
        check16("R1 pin_oe after reset", pin_oe, 16'h0000);
        check16("R1 pin_out after reset", pin_out, 16'h0000);
        check16("R1 pull_en after reset", pull_en, 16'h0000);
        check16("R13 miso_oe idle", {15'd0, miso_oe}, 16'h0000);

        // R4: compare off, address field 7 differs from strap 3 but is served
        expect_byte(8'hFF, "R1 R4 direction A reset");
        expect_byte(8'hFF, "R1 R6 direction B reset");
        rd_frame(8'h4F, 8'h00, 2);

        // R11 R6: burst write of both direction bytes
        wr_frame(8'h4E, 8'h00, 8'h0F, 8'hF0, 2);
        check16("R11 pin_oe from direction", pin_oe, 16'h0FF0);

        // R9: port write updates latch
        wr_frame(8'h40, 8'h12, 8'hA5, 8'h3C, 2);
        check16("R9 pin_out follows latch", pin_out, 16'h3CA5);
        pin_in = 16'h1234;
        expect_byte(8'hA5, "R9 latch A readback");
        expect_byte(8'h3C, "R9 latch B readback");
        rd_frame(8'h41, 8'h14, 2);

        // R10: port read with and without inversion
        expect_byte(8'h34, "R10 port A no inversion");
        expect_byte(8'h12, "R10 port B no inversion");
        rd_frame(8'h41, 8'h12, 2);
        wr_frame(8'h40, 8'h02, 8'hFF, 8'h00, 2);
        expect_byte(8'hCB, "R10 port A inverted");
        expect_byte(8'h12, "R10 port B not inverted");
        rd_frame(8'h41, 8'h12, 2);

        // R2: wrong prefix ignored
        wr_frame(8'h50, 8'h00, 8'h00, 8'h00, 2);
        check16("R2 bad prefix ignored", pin_oe, 16'h0FF0);

        // R8 R3: enable compare via bank B copy, read both copies with matching address
        wr_frame(8'h40, 8'h0B, 8'h08, 8'h00, 1);
        expect_byte(8'h08, "R8 config at bank A address");
        expect_byte(8'h08, "R8 R3 config at bank B address");
        rd_frame(8'h47, 8'h0A, 2);

        // R3: mismatched address ignored, matched served
        wr_frame(8'h4A, 8'h0C, 8'h55, 8'hAA, 2);
        check16("R3 mismatched address ignored", pull_en, 16'h0000);
        wr_frame(8'h46, 8'h0C, 8'h55, 8'hAA, 2);
        check16("R11 R3 pull_en from pull-up", pull_en, 16'hAA55);

        // R7: fixed address mode
        wr_frame(8'h46, 8'h0A, 8'h28, 8'h00, 1);
        wr_frame(8'h46, 8'h0C, 8'h11, 8'h33, 3);
        check16("R7 fixed address writes", pull_en, 16'hAA11);
        expect_byte(8'hAA, "R7 fixed read 1");
        expect_byte(8'hAA, "R7 fixed read 2");
        expect_byte(8'hAA, "R7 fixed read 3");
        rd_frame(8'h47, 8'h0D, 3);

        // R6: back to sequential, wrap from top of map
        wr_frame(8'h46, 8'h0A, 8'h08, 8'h00, 1);
        expect_byte(8'h3C, "R6 latch B before wrap");
        expect_byte(8'h0F, "R6 wrap to direction A");
        rd_frame(8'h47, 8'h15, 2);

        // R5: unmapped addresses
        wr_frame(8'h46, 8'h04, 8'h77, 8'h77, 1);
        expect_byte(8'h00, "R5 unmapped 0x04 reads zero");
        rd_frame(8'h47, 8'h04, 1);
        expect_byte(8'h00, "R5 unmapped 0x10 reads zero");
        rd_frame(8'h47, 8'h10, 1);
        check16("R5 pin_oe unchanged", pin_oe, 16'h0FF0);
        check16("R5 pin_out unchanged", pin_out, 16'h3CA5);
        check16("R5 pull_en unchanged", pull_en, 16'hAA11);

        // R12: abort mid data byte, then mid control byte
        cs_begin();
        spi_bits(8'h46, 8, rx);
        spi_bits(8'h00, 8, rx);
        spi_bits(8'hFF, 4, rx);
        cs_end();
        check16("R12 partial byte discarded", pin_oe, 16'h0FF0);
        cs_begin();
        spi_bits(8'h46, 3, rx);
        cs_end();
        expect_byte(8'h0F, "R12 frame after abort");
        rd_frame(8'h47, 8'h00, 1);

        wait_clks(20);
        check16("scoreboard drained", 16'(exp_q.size()), 16'h0000);
        finish_run();
    end

endmodule